// File: doc/BRIEF.md
# Transmit Amplitude Ramp Controller

This block shapes the power envelope of a transmit burst. It holds a 12-bit ramp factor that runs from 0 (silence) to 4095 (full scale, read as 1.0). It multiplies the I-channel and Q-channel gain words by this factor, so the scaled gains carry the envelope to the output datapath. The factor moves one step per symbol strobe. While a burst is requested it climbs by a programmable increment until it saturates at full scale, where it stays. It then descends by a programmable decrement to zero. The descent starts when the ramp-up control bit of the transmit words goes low, or when a programmable symbol count measured from the start of the burst runs out. A change of the control bit partway through a ramp turns the ramp around at the next strobe.

With ramping disabled, the block works in direct mode. The control bit then switches the factor between zero and full scale at each strobe, with no intermediate steps. A path-active flag shows that a burst is in progress. A one-cycle completion pulse marks the end of each burst. Every input is a plain level or strobe that is taken in the cycle it is presented. The block applies no back-pressure and has no valid/ready stream.

Top module: `tx_ramp_ctrl`

## Requirements
- R1: After reset the ramp factor is 0, both scaled gains are 0, and `path_active` and `done_evt` are low.
- R2: The ramp factor, the scaled gains and `path_active` change only on a clock edge where `sym_stb` is high. A `word_stb` with no `sym_stb` only records `word_up` for later use and leaves every output as it was.
- R3: In ramp mode (`ramp_en`=1), while the recorded bit is 1, each strobe adds `step_up` to the factor. The sum saturates at 4095 and never wraps. At 4095 the factor holds.
- R4: While descending, each strobe subtracts `step_dn` from the factor. The result saturates at 0. When it reaches 0 the burst ends and `path_active` goes low.
- R5: A change of the recorded bit during a climb or a descent reverses the direction at the next strobe.
- R6: The strobe that starts a burst is number 0. At strobe k of the burst, if `hold_syms` is nonzero and k ≥ `hold_syms`, the factor descends even while the recorded bit is 1. A `hold_syms` of 0 turns this timeout off.
- R7: A burst that ends while the recorded bit is still 1 does not restart. A new burst needs one strobe in the idle state with the bit at 0 first.
- R8: In direct mode (`ramp_en`=0), each strobe sets the factor to 4095 if the recorded bit is 1 and to 0 if it is 0. `path_active` follows the bit.
- R9: Each scaled gain is 0 when the factor is 0. Otherwise it is (gain × (factor+1)) >> 12. At full scale it is exactly the gain word. The I and Q channels are scaled separately.
- R10: `done_evt` is high for exactly one cycle: the first cycle in which `path_active` is low after a burst.
- R11: `path_active` rises at the strobe that starts a burst, even when a zero increment leaves the factor at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_stb | input | 1 | Symbol strobe, one ramp step per pulse |
| ramp_en | input | 1 | 1 selects ramping, 0 selects direct mode |
| word_stb | input | 1 | A transmit word's control bit is present |
| word_up | input | 1 | Ramp-up control bit of that word |
| step_up | input | 12 | Increment per strobe |
| step_dn | input | 12 | Decrement per strobe |
| hold_syms | input | 12 | Burst length in symbols before forced descent, 0 = off |
| gain_i | input | 12 | I-channel gain word |
| gain_q | input | 12 | Q-channel gain word |
| ramp | output | 12 | Current ramp factor |
| gain_i_o | output | 12 | Scaled I gain |
| gain_q_o | output | 12 | Scaled Q gain |
| path_active | output | 1 | Burst in progress |
| done_evt | output | 1 | One-cycle burst-complete pulse |

## Verification
Several rules are checked on every cycle. The factor stays still without a strobe. A nonzero factor implies an active path. Direct mode only ever yields 0 or 4095. Full scale passes the gains through unchanged. The completion pulse coincides with the fall of `path_active`. Only the bench scenarios can show the exact step values: saturation, a turnaround partway through a ramp, the symbol-count timeout firing on the right strobe, and the rule that blocks a restart after a timed-out burst.

// File: rtl/tx_ramp_pkg.sv
package tx_ramp_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_RISE = 2'd1,
    RS_HOLD = 2'd2,
    RS_FALL = 2'd3
  } ramp_state_e;
endpackage

// File: rtl/tx_hold_timer.sv
// Counts strobes since the start of a burst and reports when the
// programmed burst length has been reached at the coming strobe.
module tx_hold_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [TW-1:0] cnt;
  logic [TW:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + {{TW{1'b0}}, 1'b1};
  assign expire   = (limit != '0) && (cnt_next >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (tick && cnt != CNT_MAX) begin
      cnt <= cnt_next[TW-1:0];
    end
  end
endmodule

// File: rtl/tx_ramp_seq.sv
// Ramp factor register and its four-state sequencer.
module tx_ramp_seq
  import tx_ramp_pkg::*;
#(
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_stb,
  input  logic          ramp_en,
  input  logic          up_req,
  input  logic [RW-1:0] step_up,
  input  logic [RW-1:0] step_dn,
  input  logic          expire,
  output logic [RW-1:0] ramp,
  output logic          active,
  output logic          done_evt,
  output logic          tmr_clr,
  output logic          tmr_tick
);
  localparam logic [RW-1:0] FULL = {RW{1'b1}};

  ramp_state_e   state, state_n;
  logic [RW-1:0] ramp_n;
  logic          need_low, need_low_n;
  logic [RW:0]   sum;
  logic [RW-1:0] up_val, dn_val;
  logic          go_up;

  assign sum    = {1'b0, ramp} + {1'b0, step_up};
  assign up_val = sum[RW] ? FULL : sum[RW-1:0];
  assign dn_val = (ramp > step_dn) ? (ramp - step_dn) : '0;
  assign go_up  = up_req && !expire;

  always_comb begin
    state_n    = state;
    ramp_n     = ramp;
    need_low_n = need_low;
    if (sym_stb) begin
      if (!ramp_en) begin
        need_low_n = 1'b0;
        ramp_n     = up_req ? FULL : '0;
        state_n    = up_req ? RS_HOLD : RS_IDLE;
      end else if (state == RS_IDLE) begin
        if (!up_req) begin
          need_low_n = 1'b0;
        end else if (!need_low) begin
          ramp_n  = up_val;
          state_n = (up_val == FULL) ? RS_HOLD : RS_RISE;
        end
      end else if (go_up) begin
        ramp_n  = up_val;
        state_n = (up_val == FULL) ? RS_HOLD : RS_RISE;
      end else begin
        ramp_n  = dn_val;
        state_n = (dn_val == '0) ? RS_IDLE : RS_FALL;
        if (dn_val == '0) begin
          need_low_n = up_req;
        end
      end
    end
  end

  assign tmr_tick = sym_stb && ramp_en && (state != RS_IDLE);
  assign tmr_clr  = sym_stb && (!ramp_en || state == RS_IDLE || state_n == RS_IDLE);
  assign active   = (state != RS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RS_IDLE;
      ramp     <= '0;
      need_low <= 1'b0;
      done_evt <= 1'b0;
    end else begin
      state    <= state_n;
      ramp     <= ramp_n;
      need_low <= need_low_n;
      done_evt <= (state != RS_IDLE) && (state_n == RS_IDLE);
    end
  end
endmodule

// File: rtl/tx_gain_scaler.sv
// Scales one gain word by the ramp factor, full scale mapping to 1.0.
module tx_gain_scaler #(
  parameter int GW = 12,
  parameter int RW = 12
) (
  input  logic [GW-1:0] gain,
  input  logic [RW-1:0] ramp,
  output logic [GW-1:0] scaled
);
  localparam int PW = GW + RW + 1;

  logic [PW-1:0] prod;

  assign prod   = {{(RW+1){1'b0}}, gain} * {{GW{1'b0}}, {1'b0, ramp} + {{RW{1'b0}}, 1'b1}};
  assign scaled = (ramp == '0) ? '0 : prod[RW +: GW];
endmodule

// File: rtl/tx_ramp_ctrl.sv
module tx_ramp_ctrl #(
  parameter int RW = 12,
  parameter int GW = 12,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_stb,
  input  logic          ramp_en,
  input  logic          word_stb,
  input  logic          word_up,
  input  logic [RW-1:0] step_up,
  input  logic [RW-1:0] step_dn,
  input  logic [TW-1:0] hold_syms,
  input  logic [GW-1:0] gain_i,
  input  logic [GW-1:0] gain_q,
  output logic [RW-1:0] ramp,
  output logic [GW-1:0] gain_i_o,
  output logic [GW-1:0] gain_q_o,
  output logic          path_active,
  output logic          done_evt
);
  localparam int NCH = 2;

  logic          up_req;
  logic          expire, tmr_clr, tmr_tick;
  logic [GW-1:0] g_in  [NCH];
  logic [GW-1:0] g_out [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_req <= 1'b0;
    end else if (word_stb) begin
      up_req <= word_up;
    end
  end

  tx_hold_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tmr_clr),
    .tick   (tmr_tick),
    .limit  (hold_syms),
    .expire (expire)
  );

  tx_ramp_seq #(.RW(RW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_stb  (sym_stb),
    .ramp_en  (ramp_en),
    .up_req   (up_req),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .expire   (expire),
    .ramp     (ramp),
    .active   (path_active),
    .done_evt (done_evt),
    .tmr_clr  (tmr_clr),
    .tmr_tick (tmr_tick)
  );

  assign g_in[0] = gain_i;
  assign g_in[1] = gain_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    tx_gain_scaler #(.GW(GW), .RW(RW)) u_scale (
      .gain   (g_in[ch]),
      .ramp   (ramp),
      .scaled (g_out[ch])
    );
  end

  assign gain_i_o = g_out[0];
  assign gain_q_o = g_out[1];
endmodule

// File: rtl/tx_ramp_chk.sv
module tx_ramp_chk #(
  parameter int RW = 12,
  parameter int GW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sym_stb,
  input logic          ramp_en,
  input logic [RW-1:0] ramp,
  input logic          path_active,
  input logic          done_evt,
  input logic [GW-1:0] gain_i,
  input logic [GW-1:0] gain_q,
  input logic [GW-1:0] gain_i_o,
  input logic [GW-1:0] gain_q_o
);
  localparam logic [RW-1:0] FULL = {RW{1'b1}};

  assert_still_between_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_stb |=> $stable(ramp) && $stable(path_active));

  assert_nonzero_means_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp != '0) |-> path_active);

  assert_direct_two_levels_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && !ramp_en) |=> (ramp == '0 || ramp == FULL));

  assert_full_scale_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp == FULL) |-> (gain_i_o == gain_i && gain_q_o == gain_q));

  assert_zero_gives_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp == '0) |-> (gain_i_o == '0 && gain_q_o == '0));

  assert_done_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> $fell(path_active));
endmodule

bind tx_ramp_ctrl tx_ramp_chk #(.RW(RW), .GW(GW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sym_stb     (sym_stb),
  .ramp_en     (ramp_en),
  .ramp        (ramp),
  .path_active (path_active),
  .done_evt    (done_evt),
  .gain_i      (gain_i),
  .gain_q      (gain_q),
  .gain_i_o    (gain_i_o),
  .gain_q_o    (gain_q_o)
);

// File: tb/tx_ramp_ctrl_tb_top.sv
module tx_ramp_ctrl_tb_top;
  localparam int CLK_NS = 10;
  localparam int FULL   = 4095;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sym_stb = 1'b0, ramp_en = 1'b1, word_stb = 1'b0, word_up = 1'b0;
  logic [11:0] step_up = '0, step_dn = '0, hold_syms = '0;
  logic [11:0] gain_i = 12'd3000, gain_q = 12'd1234;
  logic [11:0] ramp, gain_i_o, gain_q_o;
  logic        path_active, done_evt;

  always #(CLK_NS/2) clk = ~clk;

  tx_ramp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .ramp_en(ramp_en),
    .word_stb(word_stb), .word_up(word_up), .step_up(step_up),
    .step_dn(step_dn), .hold_syms(hold_syms), .gain_i(gain_i),
    .gain_q(gain_q), .ramp(ramp), .gain_i_o(gain_i_o),
    .gain_q_o(gain_q_o), .path_active(path_active), .done_evt(done_evt)
  );

  typedef struct {
    int    r;
    int    act;
    int    gi;
    int    gq;
    int    dn;
    string tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;

  // model state: 0 idle, 1 rise, 2 hold, 3 fall
  int m_r = 0, m_st = 0, m_cnt = 0, m_need = 0, m_up = 0;

  function automatic int sc(int g, int r);
    return (r == 0) ? 0 : ((g * (r + 1)) >>> 12);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int was = (m_st != 0);
    if (!ramp_en) begin
      m_need = 0; m_cnt = 0;
      m_r  = m_up ? FULL : 0;
      m_st = m_up ? 2 : 0;
    end else if (m_st == 0) begin
      if (!m_up) m_need = 0;
      else if (!m_need) begin
        m_r = (int'(step_up) > FULL) ? FULL : int'(step_up);
        m_st = (m_r == FULL) ? 2 : 1;
        m_cnt = 0;
      end
    end else begin
      int expd = (hold_syms != 0) && (m_cnt + 1 >= int'(hold_syms));
      m_cnt = (m_cnt == FULL) ? FULL : m_cnt + 1;
      if (m_up && !expd) begin
        m_r = m_r + int'(step_up);
        if (m_r > FULL) m_r = FULL;
        m_st = (m_r == FULL) ? 2 : 1;
      end else begin
        m_r = m_r - int'(step_dn);
        if (m_r < 0) m_r = 0;
        m_st = (m_r == 0) ? 0 : 3;
        if (m_r == 0) begin m_need = m_up; m_cnt = 0; end
      end
    end
    q.push_back('{m_r, int'(m_st != 0), sc(gain_i, m_r), sc(gain_q, m_r),
                  int'(was && m_st == 0), ""});
  endtask

  task automatic set_up(bit b);
    @(negedge clk);
    word_up = b; word_stb = 1'b1;
    @(negedge clk);
    word_stb = 1'b0;
    m_up = b;
  endtask

  task automatic step(string tag);
    @(negedge clk);
    model_step();
    q[q.size()-1].tag = tag;
    sym_stb = 1'b1;
    @(negedge clk);
    sym_stb = 1'b0;
  endtask

  // monitor: compares one expected item per strobe edge
  initial begin
    forever begin
      @(posedge clk);
      if (sym_stb && rst_n) begin
        exp_t e;
        #(CLK_NS/4);
        if (q.size() == 0) begin
          chk("R2", "unexpected strobe", 1, 0);
        end else begin
          e = q.pop_front();
          chk(e.tag, "ramp", int'(ramp), e.r);
          chk(e.tag, "path_active", int'(path_active), e.act);
          chk("R9", "gain_i_o", int'(gain_i_o), e.gi);
          chk("R9", "gain_q_o", int'(gain_q_o), e.gq);
          chk("R10", "done_evt", int'(done_evt), e.dn);
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 100000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ramp", int'(ramp), 0);
    chk("R1", "path_active", int'(path_active), 0);
    chk("R1", "gain_i_o", int'(gain_i_o), 0);
    chk("R1", "done_evt", int'(done_evt), 0);

    // plain burst, timeout off
    step_up = 12'd1000; step_dn = 12'd1500; hold_syms = 12'd0;
    set_up(1'b1);
    chk("R2", "ramp after word only", int'(ramp), 0);
    chk("R2", "active after word only", int'(path_active), 0);
    step("R11");
    for (int i = 0; i < 5; i++) step("R3");
    set_up(1'b0);
    chk("R2", "ramp held after word only", int'(ramp), FULL);
    step("R4"); step("R4"); step("R10");
    step("R4");

    // turnaround partway through both directions
    step_up = 12'd700; step_dn = 12'd500;
    set_up(1'b1);
    step("R3"); step("R3");
    set_up(1'b0);
    step("R5"); step("R4");
    set_up(1'b1);
    step("R5");
    set_up(1'b0);
    step("R5"); step("R4"); step("R4");

    // symbol-count timeout
    step_up = 12'd2048; step_dn = 12'd1024; hold_syms = 12'd5;
    set_up(1'b1);
    for (int i = 0; i < 6; i++) step("R6");
    step("R6"); step("R6"); step("R6");
    step("R7"); step("R7");
    set_up(1'b0);
    step("R7");
    set_up(1'b1);
    step("R7");
    set_up(1'b0);
    step("R4"); step("R4");

    // zero increment still opens the path
    step_up = 12'd0;
    set_up(1'b1);
    step("R11"); step("R11");
    set_up(1'b0);
    step("R4");

    // direct mode
    ramp_en = 1'b0;
    set_up(1'b1);
    step("R8"); step("R8");
    set_up(1'b0);
    step("R8");

    repeat (3) @(negedge clk);
    chk("R10", "done_evt cleared", int'(done_evt), 0);
    chk("R8", "queue drained", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule